// File: doc/BRIEF.md
# Iterative 80-bit-key SPN block encryptor

This block encrypts one 64-bit plaintext block under an 80-bit key with a 31-round substitution-permutation network. One whole round is computed per clock: the round key is mixed into the state, sixteen 4-bit substitution boxes act on the nibbles, and a fixed bit shuffle spreads the result. The 80-bit key register produces the next round key at the same time, so no key expansion happens before encryption starts.

A key is written once through a plain strobe and kept for every later block. Plaintext enters over a valid/ready stream and ciphertext leaves over a valid/ready stream. The input is ready only while the engine is idle and holds no result. A result waits, unchanged, until the consumer raises `ct_ready`, and no new block is taken before then. A one-cycle `done` pulse and a live round counter are plain status outputs.

Top module: `spn_enc80`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `pt_ready` is 1 and `ct_valid`, `done` and `round_cnt` are 0.
- R2: A block is taken at a rising edge where `pt_valid` and `pt_ready` are both 1. `pt_ready` is 1 only when the engine is idle and holds no result. It stays 0 from the taking edge until the edge where the result is handed off.
- R3: `round_cnt` is 1 in the cycle after a block is taken and rises by one each cycle up to 31. It is 0 in the cycle after it shows 31 and whenever the engine is idle.
- R4: The substitution box maps the nibble values 0 to F, in that order, to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. It acts on all sixteen state nibbles (bits 4n+3..4n) in parallel.
- R5: The bit shuffle moves state bit i to position (16*i) mod 63 for i from 0 to 62. Bit 63 stays in place.
- R6: The round key is bits 79..16 of the key register. After each round r (r = 1..31), the register is rotated left by 61 places. Then its bits 79..76 pass through the R4 box. Then bits 19..15 are XORed with r, with the LSB of r at bit 15.
- R7: Each round XORs the round key into the state, then substitutes, then shuffles. After round 31 the state is XORed once more with bits 79..16 of the key register, and the result is the ciphertext.
- R8: These known pairs (key, plaintext → ciphertext, in hex) are met: all-zero key and plaintext → 5579C1387B228445. All-ones key and plaintext → 3333DCD3213210D2. Zero key with all-ones plaintext → A112FFC72F68417B. All-ones key with zero plaintext → E72C46C0F5945049.
- R9: `done` is high for exactly one cycle per block, 32 rising edges after the taking edge. `ct_valid` rises in that same cycle.
- R10: While `ct_valid` is 1 and `ct_ready` is 0, `ct_valid` stays 1 and `ct_data` does not change. `ct_valid` falls after the edge where `ct_ready` is 1. `ct_data` keeps its value until the next block is taken.
- R11: A key written with `key_ld` while a block is being encrypted does not change that block's ciphertext. Every block taken afterwards uses the new key.
- R12: A loaded key stays in use for any number of later blocks without being written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| key_ld | input | 1 | Write strobe for the key |
| key_in | input | 80 | Key value captured when `key_ld` is 1 |
| pt_valid | input | 1 | Plaintext offered |
| pt_ready | output | 1 | Engine will take a plaintext |
| pt_data | input | 64 | Plaintext block |
| ct_valid | output | 1 | Ciphertext waiting |
| ct_ready | input | 1 | Consumer takes the ciphertext |
| ct_data | output | 64 | Ciphertext block |
| round_cnt | output | 5 | Round now being computed, 0 when idle |
| done | output | 1 | One-cycle pulse when a ciphertext appears |

## Verification
The properties assume that reset is held low for at least one rising edge and that `pt_valid` and `ct_ready` are known after reset. They also assume that `key_ld` is not raised in the same cycle as a block is taken, because which key that block uses is left open. The stimulus changes inputs only a short time after each rising edge. It never pulses `key_ld` in a cycle where `pt_ready` and `pt_valid` are both high. It moves `ct_ready` between always-high, random and held-low patterns, so that every back-pressure case the properties cover is reached.

// File: rtl/spn_pkg.sv
package spn_pkg;

  localparam int BLK_W   = 64;
  localparam int KEY_W   = 80;
  localparam int CNT_W   = 5;
  localparam int NROUNDS = 31;
  localparam int NIB_W   = 4;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RUN    = 2'd1,
    PH_WHITEN = 2'd2
  } phase_e;

  function automatic logic [NIB_W-1:0] sbox4(input logic [NIB_W-1:0] x);
    logic [NIB_W-1:0] y;
    case (x)
      4'h0: y = 4'hC;
      4'h1: y = 4'h5;
      4'h2: y = 4'h6;
      4'h3: y = 4'hB;
      4'h4: y = 4'h9;
      4'h5: y = 4'h0;
      4'h6: y = 4'hA;
      4'h7: y = 4'hD;
      4'h8: y = 4'h3;
      4'h9: y = 4'hE;
      4'hA: y = 4'hF;
      4'hB: y = 4'h8;
      4'hC: y = 4'h4;
      4'hD: y = 4'h7;
      4'hE: y = 4'h1;
      default: y = 4'h2;
    endcase
    return y;
  endfunction

endpackage

// File: rtl/spn_sub_layer.sv
module spn_sub_layer
  import spn_pkg::*;
#(
  parameter int BLOCK_W = BLK_W
) (
  input  logic [BLOCK_W-1:0] din,
  output logic [BLOCK_W-1:0] dout
);
  localparam int NNIB = BLOCK_W / NIB_W;

  for (genvar g = 0; g < NNIB; g++) begin : g_box
    assign dout[NIB_W*g +: NIB_W] = sbox4(din[NIB_W*g +: NIB_W]);
  end
endmodule

// File: rtl/spn_perm_layer.sv
module spn_perm_layer #(
  parameter int BLOCK_W = 64
) (
  input  logic [BLOCK_W-1:0] din,
  output logic [BLOCK_W-1:0] dout
);
  localparam int STRIDE = BLOCK_W / 4;
  localparam int MODV   = BLOCK_W - 1;

  // bit i lands at (STRIDE*i) mod (BLOCK_W-1); the top bit stays put
  for (genvar i = 0; i < BLOCK_W; i++) begin : g_wire
    localparam int DST = (i == BLOCK_W - 1) ? (BLOCK_W - 1) : ((i * STRIDE) % MODV);
    assign dout[DST] = din[i];
  end
endmodule

// File: rtl/spn_round.sv
module spn_round
  import spn_pkg::*;
#(
  parameter int BLOCK_W = BLK_W
) (
  input  logic [BLOCK_W-1:0] state_i,
  input  logic [BLOCK_W-1:0] rkey_i,
  output logic [BLOCK_W-1:0] state_o
);
  logic [BLOCK_W-1:0] mixed;
  logic [BLOCK_W-1:0] subbed;

  assign mixed = state_i ^ rkey_i;

  spn_sub_layer #(.BLOCK_W(BLOCK_W)) u_sub (
    .din  (mixed),
    .dout (subbed)
  );

  spn_perm_layer #(.BLOCK_W(BLOCK_W)) u_perm (
    .din  (subbed),
    .dout (state_o)
  );
endmodule

// File: rtl/spn_key_next.sv
module spn_key_next
  import spn_pkg::*;
#(
  parameter int KEY_W_P = KEY_W,
  parameter int CNT_W_P = CNT_W,
  parameter int ROT     = 61,
  parameter int CTR_LSB = 15
) (
  input  logic [KEY_W_P-1:0] key_i,
  input  logic [CNT_W_P-1:0] rnd_i,
  output logic [KEY_W_P-1:0] key_o
);
  logic [KEY_W_P-1:0] rotated;

  assign rotated = {key_i[KEY_W_P-ROT-1:0], key_i[KEY_W_P-1:KEY_W_P-ROT]};

  always_comb begin
    key_o = rotated;
    key_o[KEY_W_P-1 -: NIB_W]   = sbox4(rotated[KEY_W_P-1 -: NIB_W]);
    key_o[CTR_LSB +: CNT_W_P]   = rotated[CTR_LSB +: CNT_W_P] ^ rnd_i;
  end
endmodule

// File: rtl/spn_enc80.sv
module spn_enc80
  import spn_pkg::*;
#(
  parameter int BLOCK_W = BLK_W,
  parameter int KEY_BW  = KEY_W,
  parameter int RC_W    = CNT_W,
  parameter int ROUNDS  = NROUNDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_ld,
  input  logic [KEY_BW-1:0] key_in,
  input  logic              pt_valid,
  output logic              pt_ready,
  input  logic [BLOCK_W-1:0] pt_data,
  output logic              ct_valid,
  input  logic              ct_ready,
  output logic [BLOCK_W-1:0] ct_data,
  output logic [RC_W-1:0]   round_cnt,
  output logic              done
);
  localparam logic [RC_W-1:0] LAST_RND = RC_W'(ROUNDS);

  phase_e             phase_q;
  logic [KEY_BW-1:0]  key_hold_q;
  logic [KEY_BW-1:0]  key_q;
  logic [KEY_BW-1:0]  key_d;
  logic [BLOCK_W-1:0] st_q;
  logic [BLOCK_W-1:0] st_d;
  logic [BLOCK_W-1:0] rkey;
  logic [RC_W-1:0]    rnd_q;
  logic [BLOCK_W-1:0] ct_q;
  logic               ctv_q;
  logic               done_q;
  logic               take;

  assign rkey     = key_q[KEY_BW-1 -: BLOCK_W];
  assign pt_ready = (phase_q == PH_IDLE) && !ctv_q;
  assign take     = pt_valid && pt_ready;

  spn_round #(.BLOCK_W(BLOCK_W)) u_round (
    .state_i (st_q),
    .rkey_i  (rkey),
    .state_o (st_d)
  );

  spn_key_next #(.KEY_W_P(KEY_BW), .CNT_W_P(RC_W)) u_knext (
    .key_i (key_q),
    .rnd_i (rnd_q),
    .key_o (key_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      key_hold_q <= '0;
      key_q      <= '0;
      st_q       <= '0;
      rnd_q      <= '0;
      ct_q       <= '0;
      ctv_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (key_ld) key_hold_q <= key_in;
      if (ctv_q && ct_ready) ctv_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (take) begin
            st_q    <= pt_data;
            key_q   <= key_hold_q;
            rnd_q   <= RC_W'(1);
            phase_q <= PH_RUN;
          end
        end
        PH_RUN: begin
          st_q  <= st_d;
          key_q <= key_d;
          if (rnd_q == LAST_RND) begin
            rnd_q   <= '0;
            phase_q <= PH_WHITEN;
          end else begin
            rnd_q <= rnd_q + RC_W'(1);
          end
        end
        PH_WHITEN: begin
          ct_q    <= st_q ^ rkey;
          ctv_q   <= 1'b1;
          done_q  <= 1'b1;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign ct_valid  = ctv_q;
  assign ct_data   = ct_q;
  assign round_cnt = rnd_q;
  assign done      = done_q;
endmodule

// File: rtl/spn_enc80_chk.sv
module spn_enc80_chk #(
  parameter int BLOCK_W = 64,
  parameter int RC_W    = 5,
  parameter int ROUNDS  = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pt_valid,
  input logic              pt_ready,
  input logic              ct_valid,
  input logic              ct_ready,
  input logic [BLOCK_W-1:0] ct_data,
  input logic [RC_W-1:0]   round_cnt,
  input logic              done
);
  localparam logic [RC_W-1:0] LAST = RC_W'(ROUNDS);

  assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (round_cnt != '0) |-> !pt_ready);

  assert_start_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_valid && pt_ready) |=> (round_cnt == RC_W'(1)));

  assert_round_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (round_cnt != '0 && round_cnt != LAST) |=> (round_cnt == $past(round_cnt) + RC_W'(1)));

  assert_round_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (round_cnt == LAST) |=> (round_cnt == '0));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(ct_valid));

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ct_valid && !ct_ready) |=> (ct_valid && $stable(ct_data)));

  assert_no_take_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ct_valid |-> !pt_ready);
endmodule

bind spn_enc80 spn_enc80_chk #(.BLOCK_W(BLOCK_W), .RC_W(RC_W), .ROUNDS(ROUNDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pt_valid  (pt_valid),
  .pt_ready  (pt_ready),
  .ct_valid  (ct_valid),
  .ct_ready  (ct_ready),
  .ct_data   (ct_data),
  .round_cnt (round_cnt),
  .done      (done)
);

// File: tb/sim_spn_enc80.sv
`timescale 1ns/1ps
module sim_spn_enc80;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_ld = 1'b0;
  logic [79:0] key_in = '0;
  logic        pt_valid = 1'b0;
  logic        pt_ready;
  logic [63:0] pt_data = '0;
  logic        ct_valid;
  logic        ct_ready = 1'b1;
  logic [63:0] ct_data;
  logic [4:0]  round_cnt;
  logic        done;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int acc_cyc = 0;
  int sent = 0;
  int dones = 0;
  int rdy_mode = 0;
  bit finished = 1'b0;
  logic [79:0] cur_key = '0;
  logic [63:0] exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spn_enc80 u0 (
    .clk(clk), .rst_n(rst_n), .key_ld(key_ld), .key_in(key_in),
    .pt_valid(pt_valid), .pt_ready(pt_ready), .pt_data(pt_data),
    .ct_valid(ct_valid), .ct_ready(ct_ready), .ct_data(ct_data),
    .round_cnt(round_cnt), .done(done)
  );

  localparam logic [3:0] SB [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                                     4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};

  function automatic logic [63:0] ref_enc(logic [63:0] p, logic [79:0] k);
    logic [63:0] s = p;
    logic [63:0] t;
    logic [79:0] kk = k;
    for (int r = 1; r <= 31; r++) begin
      t = s ^ kk[79:16];
      for (int n = 0; n < 16; n++) t[4*n +: 4] = SB[t[4*n +: 4]];
      s = '0;
      for (int b = 0; b < 64; b++) s[(b == 63) ? 63 : (b * 16) % 63] = t[b];
      kk = {kk[18:0], kk[79:19]};
      kk[79:76] = SB[kk[79:76]];
      kk[19:15] = kk[19:15] ^ 5'(r);
    end
    return s ^ kk[79:16];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic load_key(input logic [79:0] k);
    @(posedge clk); #2;
    key_ld = 1'b1; key_in = k; cur_key = k;
    @(posedge clk); #2;
    key_ld = 1'b0;
  endtask

  task automatic send(input logic [63:0] p, input logic [63:0] expv);
    @(posedge clk); #2;
    pt_valid = 1'b1; pt_data = p;
    exp_q.push_back(expv);
    do @(negedge clk); while (!pt_ready);
    acc_cyc = cyc;
    sent++;
    @(posedge clk); #2;
    pt_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (exp_q.size() != 0 || ct_valid);
  endtask

  // ready driver
  initial forever begin
    @(posedge clk); #2;
    case (rdy_mode)
      1: ct_ready = 1'($urandom % 2);
      2: ct_ready = 1'b0;
      default: ct_ready = 1'b1;
    endcase
  end

  // scoreboard monitor
  bit hold_prev = 1'b0;
  logic [63:0] prev_ct = '0;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (hold_prev)
        chk(ct_valid && ct_data == prev_ct, "R10 hold", {15'd0, ct_valid, ct_data}, {16'd1, prev_ct});
      if (done) begin
        dones++;
        chk(cyc == acc_cyc + 33, "R9 latency", 80'(cyc - acc_cyc), 80'd33);
        chk(ct_valid, "R9 valid with done", 80'(ct_valid), 80'd1);
      end
      if (ct_valid) chk(!pt_ready, "R10 no take while pending", 80'(pt_ready), 80'd0);
      if (ct_valid && ct_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected output", 80'(ct_data), 80'd0);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk(ct_data == e, "R4/R5/R6/R7/R8 ciphertext", 80'(ct_data), 80'(e));
        end
      end
      hold_prev = ct_valid && !ct_ready;
      prev_ct = ct_data;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pt_ready && !ct_valid && !done && round_cnt == 0, "R1 in reset",
        {ct_valid, done, pt_ready, round_cnt}, {8'b00100000});
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    chk(pt_ready && !ct_valid && !done && round_cnt == 0, "R1 after reset",
        {ct_valid, done, pt_ready, round_cnt}, {8'b00100000});

    // R8 zero vector, with round counter walk (R2, R3)
    load_key(80'h0);
    send(64'h0, 64'h5579C1387B228445);
    for (int k = 1; k <= 31; k++) begin
      @(negedge clk);
      chk(round_cnt == 5'(k), "R3 round count", 80'(round_cnt), 80'(k));
      chk(!pt_ready, "R2 ready low while busy", 80'(pt_ready), 80'd0);
    end
    @(negedge clk);
    chk(round_cnt == 0, "R3 count back to zero", 80'(round_cnt), 80'd0);
    drain();
    @(negedge clk);
    chk(pt_ready, "R2 ready after handoff", 80'(pt_ready), 80'd1);

    // R8 remaining known pairs
    load_key({80{1'b1}});
    send({64{1'b1}}, 64'h3333DCD3213210D2);
    drain();
    send(64'h0, 64'hE72C46C0F5945049);
    drain();
    load_key(80'h0);
    send({64{1'b1}}, 64'hA112FFC72F68417B);
    drain();

    // R12 key kept over several blocks
    load_key(80'h0123_4567_89AB_CDEF_1357);
    for (int i = 0; i < 4; i++) begin
      logic [63:0] p;
      p = {$urandom, $urandom};
      send(p, ref_enc(p, cur_key));
      drain();
    end

    // R11 key write during encryption
    begin
      logic [79:0] kold;
      logic [63:0] p;
      kold = cur_key;
      p = 64'hDEAD_BEEF_0BAD_F00D;
      send(p, ref_enc(p, kold));
      repeat (5) @(posedge clk);
      load_key(80'hFACE_0000_1111_2222_3333);
      drain();
      send(p, ref_enc(p, cur_key));
      drain();
    end

    // R10 result held with ready low
    rdy_mode = 2;
    send(64'h1122_3344_5566_7788, ref_enc(64'h1122_3344_5566_7788, cur_key));
    repeat (45) @(negedge clk);
    chk(ct_valid, "R10 valid held", 80'(ct_valid), 80'd1);
    chk(exp_q.size() == 1, "R10 not consumed", 80'(exp_q.size()), 80'd1);
    chk(!pt_ready, "R10 input blocked", 80'(pt_ready), 80'd0);
    rdy_mode = 0;
    drain();

    // R10 random back-pressure
    rdy_mode = 1;
    for (int i = 0; i < 6; i++) begin
      logic [63:0] p;
      p = {$urandom, $urandom};
      send(p, ref_enc(p, cur_key));
    end
    rdy_mode = 0;
    drain();
    repeat (3) @(negedge clk);
    chk(dones == sent, "R9 one done per block", 80'(dones), 80'(sent));
    chk(exp_q.size() == 0, "R7 all results seen", 80'(exp_q.size()), 80'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule